// File: doc/BRIEF.md
# Condition Flag Compare-Branch Unit

This block is the condition-code stage of a small processor pipeline. A compare or bit-test operation computes one result bit and stores it in a one-bit condition flag. A later conditional jump or conditional register move reads only that stored flag. It never compares operands itself.

Compares check equality, less-than or less-than-or-equal, in a signed or an unsigned form. The second operand is either a register or a 3-bit immediate. For a jump, the unit adds a sign-extended byte offset to the instruction PC. It raises a redirect when the flag agrees with the instruction's sense bit. It also flags an offset whose low bit is set and suppresses the jump in that case. For a move, it raises a write enable for the destination register under the same sense rule.

The flag sits in a register. An operation issued in the cycle right after a compare therefore reads that compare's result without any extra stall.

Top module: `cfu_top`

## Requirements
- R1: While `rstN` is low, `condFlag` is 0. After reset it stays 0 until the first flag-writing operation.
- R2: Compare opcodes and their relations:
  - 4'h1: equal.
  - 4'h2: signed less-than.
  - 4'h3: signed less-or-equal.
  - 4'h4: unsigned less-than.
  - 4'h5: unsigned less-or-equal.
  - 4'h6: equal, with a zero-extended immediate.

  Each compare tests `regA` against the second operand. It writes the result to `condFlag` at the next rising clock edge. With `useImm`=0 the second operand is `regB`.
- R3: With `useImm`=1 the second operand is `immVal`. Opcodes 4'h1 to 4'h3 sign-extend it, giving -4..3. Opcodes 4'h4 to 4'h6 zero-extend it, giving 0..7.
- R4: Opcode 4'h7 (bit test) writes `regA[bitIdx]` to `condFlag` at the next rising edge, for any `bitIdx` from 0 to 31.
- R5: All other opcodes leave `condFlag` unchanged. These are 4'h0, 4'h8, 4'h9 and 4'hA to 4'hF.
- R6: During opcode 4'h8 (jump), `branchTaken` is 1 in the same cycle exactly when `condFlag` equals `sense` and `offsetEnc[0]` is 0. With any other opcode `branchTaken` is 0.
- R7: During opcode 4'h8, `branchTarget` equals `pcIn` plus `offsetEnc` sign-extended from 11 bits. This covers offsets from -1024 to +1022, and the sum wraps modulo 2^32.
- R8: During opcode 4'h8 with `offsetEnc[0]`=1, `illegalOffset` is 1 and `branchTaken` is 0. `illegalOffset` is 0 in every other case.
- R9: During opcode 4'h9 (conditional move), `moveEnable` is 1 exactly when `condFlag` equals `sense`. With any other opcode `moveEnable` is 0.
- R10: A jump or move issued in the cycle directly after a compare or bit test is decided on that compare's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| opCode | input | 4 | Operation selector |
| useImm | input | 1 | Select `immVal` instead of `regB` as second compare operand |
| immVal | input | 3 | Short immediate operand |
| bitIdx | input | 5 | Bit index for bit test |
| regA | input | 32 | First operand / bit-test source |
| regB | input | 32 | Second register operand |
| sense | input | 1 | Required flag value for jump or move |
| pcIn | input | 32 | Address of the current instruction |
| offsetEnc | input | 11 | Encoded signed byte offset for jump |
| condFlag | output | 1 | Stored condition flag |
| branchTaken | output | 1 | Redirect request for a taken jump |
| branchTarget | output | 32 | PC-relative jump target |
| moveEnable | output | 1 | Write enable for a conditional move |
| illegalOffset | output | 1 | Jump offset has bit 0 set |

## Verification
Two things can meet in one cycle. One is a jump or move that reads the flag. The other is the flag update from the compare issued just before it, so the consumer must see the new value rather than the one from two operations back.

Directed sequences issue a compare that flips the flag and follow it at once with a jump or move. The bench judges the outcome against a model flag updated at the same edge. Random sequences with no gaps between operations provoke the same collision many times with both sense values.

An odd offset that arrives together with a matching flag is also forced. In that cycle the illegal indication must win over the redirect.

// File: rtl/cfu_pkg.sv
package cfu_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOP  = 4'h0,
    OP_EQ   = 4'h1,
    OP_LT   = 4'h2,
    OP_LE   = 4'h3,
    OP_LTU  = 4'h4,
    OP_LEU  = 4'h5,
    OP_EQU  = 4'h6,
    OP_BIT  = 4'h7,
    OP_JUMP = 4'h8,
    OP_MOVE = 4'h9
  } opKind_e;

  typedef enum logic [1:0] {
    REL_EQ,
    REL_LT,
    REL_LE,
    REL_BIT
  } relSel_e;

  typedef struct packed {
    logic    flagWrite;
    logic    selImm;
    logic    signedCmp;
    relSel_e rel;
    logic    jumpReq;
    logic    moveReq;
  } ctrlStrobe_t;

endpackage

// File: rtl/cfu_ctrl.sv
module cfu_ctrl
  import cfu_pkg::*;
(
  input  logic [OP_W-1:0] opCode,
  input  logic            useImm,
  output ctrlStrobe_t     strobes
);

  opKind_e opKind;

  assign opKind = opKind_e'(opCode);

  always_comb begin
    strobes           = '0;
    strobes.rel       = REL_EQ;
    strobes.selImm    = useImm;
    case (opKind)
      OP_EQ: begin
        strobes.flagWrite = 1'b1;
        strobes.signedCmp = 1'b1;
        strobes.rel       = REL_EQ;
      end
      OP_LT: begin
        strobes.flagWrite = 1'b1;
        strobes.signedCmp = 1'b1;
        strobes.rel       = REL_LT;
      end
      OP_LE: begin
        strobes.flagWrite = 1'b1;
        strobes.signedCmp = 1'b1;
        strobes.rel       = REL_LE;
      end
      OP_LTU: begin
        strobes.flagWrite = 1'b1;
        strobes.rel       = REL_LT;
      end
      OP_LEU: begin
        strobes.flagWrite = 1'b1;
        strobes.rel       = REL_LE;
      end
      OP_EQU: begin
        strobes.flagWrite = 1'b1;
        strobes.rel       = REL_EQ;
      end
      OP_BIT: begin
        strobes.flagWrite = 1'b1;
        strobes.selImm    = 1'b0;
        strobes.rel       = REL_BIT;
      end
      OP_JUMP: strobes.jumpReq = 1'b1;
      OP_MOVE: strobes.moveReq = 1'b1;
      default: strobes.selImm = 1'b0;
    endcase
  end

endmodule

// File: rtl/cfu_datapath.sv
module cfu_datapath
  import cfu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 3,
  parameter int OFF_W  = 11,
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobes,
  input  logic [IMM_W-1:0]  immVal,
  input  logic [IDX_W-1:0]  bitIdx,
  input  logic [DATA_W-1:0] regA,
  input  logic [DATA_W-1:0] regB,
  input  logic              sense,
  input  logic [DATA_W-1:0] pcIn,
  input  logic [OFF_W-1:0]  offsetEnc,
  output logic              condFlag,
  output logic              branchTaken,
  output logic [DATA_W-1:0] branchTarget,
  output logic              moveEnable,
  output logic              illegalOffset
);

  localparam int IMM_PAD = DATA_W - IMM_W;
  localparam int OFF_PAD = DATA_W - OFF_W;

  logic [DATA_W-1:0] immSigned;
  logic [DATA_W-1:0] immUnsigned;
  logic [DATA_W-1:0] operandB;
  logic              isEqual;
  logic              lessSigned;
  logic              lessUnsigned;
  logic              isLess;
  logic              bitValue;
  logic              cmpResult;
  logic              flagQ;
  logic              senseMatch;
  logic [DATA_W-1:0] offsetExt;

  // second operand selection
  assign immSigned   = {{IMM_PAD{immVal[IMM_W-1]}}, immVal};
  assign immUnsigned = {{IMM_PAD{1'b0}}, immVal};

  always_comb begin
    if (!strobes.selImm)        operandB = regB;
    else if (strobes.signedCmp) operandB = immSigned;
    else                        operandB = immUnsigned;
  end

  // relation evaluation
  assign isEqual      = (regA == operandB);
  assign lessSigned   = ($signed(regA) < $signed(operandB));
  assign lessUnsigned = (regA < operandB);
  assign isLess       = strobes.signedCmp ? lessSigned : lessUnsigned;
  assign bitValue     = regA[bitIdx];

  always_comb begin
    case (strobes.rel)
      REL_EQ:  cmpResult = isEqual;
      REL_LT:  cmpResult = isLess;
      REL_LE:  cmpResult = isLess | isEqual;
      default: cmpResult = bitValue;
    endcase
  end

  // stored condition flag
  always_ff @(posedge clk) begin
    if (!rstN)                  flagQ <= 1'b0;
    else if (strobes.flagWrite) flagQ <= cmpResult;
  end

  assign condFlag   = flagQ;
  assign senseMatch = (flagQ == sense);

  // jump resolution
  assign offsetExt     = {{OFF_PAD{offsetEnc[OFF_W-1]}}, offsetEnc};
  assign branchTarget  = pcIn + offsetExt;
  assign illegalOffset = strobes.jumpReq & offsetEnc[0];
  assign branchTaken   = strobes.jumpReq & senseMatch & ~offsetEnc[0];

  // conditional move resolution
  assign moveEnable = strobes.moveReq & senseMatch;

endmodule

// File: rtl/cfu_top.sv
module cfu_top
  import cfu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 3,
  parameter int OFF_W  = 11,
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        opCode,
  input  logic              useImm,
  input  logic [IMM_W-1:0]  immVal,
  input  logic [IDX_W-1:0]  bitIdx,
  input  logic [DATA_W-1:0] regA,
  input  logic [DATA_W-1:0] regB,
  input  logic              sense,
  input  logic [DATA_W-1:0] pcIn,
  input  logic [OFF_W-1:0]  offsetEnc,
  output logic              condFlag,
  output logic              branchTaken,
  output logic [DATA_W-1:0] branchTarget,
  output logic              moveEnable,
  output logic              illegalOffset
);

  ctrlStrobe_t strobes;

  cfu_ctrl i_ctrl (
    .opCode  (opCode),
    .useImm  (useImm),
    .strobes (strobes)
  );

  cfu_datapath #(
    .DATA_W (DATA_W),
    .IMM_W  (IMM_W),
    .OFF_W  (OFF_W),
    .IDX_W  (IDX_W)
  ) i_datapath (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .immVal        (immVal),
    .bitIdx        (bitIdx),
    .regA          (regA),
    .regB          (regB),
    .sense         (sense),
    .pcIn          (pcIn),
    .offsetEnc     (offsetEnc),
    .condFlag      (condFlag),
    .branchTaken   (branchTaken),
    .branchTarget  (branchTarget),
    .moveEnable    (moveEnable),
    .illegalOffset (illegalOffset)
  );

endmodule

// File: rtl/cfu_checker.sv
module cfu_checker #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 3,
  parameter int OFF_W  = 11,
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rstN,
  input logic [3:0]        opCode,
  input logic              useImm,
  input logic [IMM_W-1:0]  immVal,
  input logic [IDX_W-1:0]  bitIdx,
  input logic [DATA_W-1:0] regA,
  input logic [DATA_W-1:0] regB,
  input logic              sense,
  input logic [DATA_W-1:0] pcIn,
  input logic [OFF_W-1:0]  offsetEnc,
  input logic              condFlag,
  input logic              branchTaken,
  input logic [DATA_W-1:0] branchTarget,
  input logic              moveEnable,
  input logic              illegalOffset
);

  AST_RESET_CLEARS: assert property (@(posedge clk) $rose(rstN) |-> !condFlag); // R1

  AST_EQ_REG: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 4'h1 && !useImm) |=> (condFlag == $past(regA == regB))); // R2

  AST_BIT_TEST: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 4'h7) |=> (condFlag == $past(regA[bitIdx]))); // R4

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 4'h0 || opCode >= 4'h8) |=> $stable(condFlag)); // R5

  AST_TAKEN_GATE: assert property (@(posedge clk) disable iff (!rstN)
    branchTaken |-> (opCode == 4'h8 && condFlag == sense && !offsetEnc[0])); // R6

  AST_ILLEGAL_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    illegalOffset |-> (!branchTaken && opCode == 4'h8)); // R8

  AST_MOVE_GATE: assert property (@(posedge clk) disable iff (!rstN)
    moveEnable |-> (opCode == 4'h9 && condFlag == sense)); // R9

endmodule

bind cfu_top cfu_checker #(
  .DATA_W (DATA_W),
  .IMM_W  (IMM_W),
  .OFF_W  (OFF_W),
  .IDX_W  (IDX_W)
) i_checker (
  .clk           (clk),
  .rstN          (rstN),
  .opCode        (opCode),
  .useImm        (useImm),
  .immVal        (immVal),
  .bitIdx        (bitIdx),
  .regA          (regA),
  .regB          (regB),
  .sense         (sense),
  .pcIn          (pcIn),
  .offsetEnc     (offsetEnc),
  .condFlag      (condFlag),
  .branchTaken   (branchTaken),
  .branchTarget  (branchTarget),
  .moveEnable    (moveEnable),
  .illegalOffset (illegalOffset)
);

// File: tb/test_cfu_top.sv
module test_cfu_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  opCode = '0;
  logic        useImm = 1'b0;
  logic [2:0]  immVal = '0;
  logic [4:0]  bitIdx = '0;
  logic [31:0] regA = '0;
  logic [31:0] regB = '0;
  logic        sense = 1'b0;
  logic [31:0] pcIn = '0;
  logic [10:0] offsetEnc = '0;
  logic        condFlag;
  logic        branchTaken;
  logic [31:0] branchTarget;
  logic        moveEnable;
  logic        illegalOffset;

  int checks = 0;
  int failures = 0;
  logic mFlag = 1'b0;
  logic summaryDone = 1'b0;

  always #5 clk = ~clk;

  cfu_top i_cfu_top (
    .clk           (clk),
    .rstN          (rstN),
    .opCode        (opCode),
    .useImm        (useImm),
    .immVal        (immVal),
    .bitIdx        (bitIdx),
    .regA          (regA),
    .regB          (regB),
    .sense         (sense),
    .pcIn          (pcIn),
    .offsetEnc     (offsetEnc),
    .condFlag      (condFlag),
    .branchTaken   (branchTaken),
    .branchTarget  (branchTarget),
    .moveEnable    (moveEnable),
    .illegalOffset (illegalOffset)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!summaryDone) begin
      summaryDone = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
    $finish;
  endtask

  function automatic logic expFlag(logic [3:0] op, logic [31:0] a, logic [31:0] b,
                                   logic ui, logic [2:0] imm, logic [4:0] idx, logic old);
    logic [31:0] opB;
    if (!ui)                      opB = b;
    else if (op >= 4'h1 && op <= 4'h3) opB = {{29{imm[2]}}, imm};
    else                          opB = {29'd0, imm};
    case (op)
      4'h1, 4'h6: return a == opB;
      4'h2:       return $signed(a) < $signed(opB);
      4'h3:       return $signed(a) <= $signed(opB);
      4'h4:       return a < opB;
      4'h5:       return a <= opB;
      4'h7:       return a[idx];
      default:    return old;
    endcase
  endfunction

  function automatic string flagTag(logic [3:0] op, logic ui);
    if (op >= 4'h1 && op <= 4'h6) return ui ? "R3" : "R2";
    if (op == 4'h7) return "R4";
    return "R5";
  endfunction

  string lastTag = "R1";

  // one operation per cycle; outputs checked 1 ns after driving, away from the edge
  task automatic doOp(logic [3:0] op, logic [31:0] a, logic [31:0] b, logic ui,
                      logic [2:0] imm, logic [4:0] idx, logic sn, logic [31:0] pc,
                      logic [10:0] off, string tagOverride);
    string t;
    @(negedge clk);
    check(lastTag, "condFlag", {31'd0, condFlag}, {31'd0, mFlag});
    opCode = op; regA = a; regB = b; useImm = ui; immVal = imm;
    bitIdx = idx; sense = sn; pcIn = pc; offsetEnc = off;
    #1;
    if (op == 4'h8) begin
      t = (tagOverride != "") ? tagOverride : (off[0] ? "R8" : "R6");
      check(t, "branchTaken", {31'd0, branchTaken}, {31'd0, (mFlag == sn) && !off[0]});
      check("R8", "illegalOffset", {31'd0, illegalOffset}, {31'd0, off[0]});
      check("R7", "branchTarget", branchTarget, pc + {{21{off[10]}}, off});
    end else begin
      check("R6", "branchTaken idle", {31'd0, branchTaken}, 32'd0);
      check("R8", "illegalOffset idle", {31'd0, illegalOffset}, 32'd0);
    end
    if (op == 4'h9) begin
      t = (tagOverride != "") ? tagOverride : "R9";
      check(t, "moveEnable", {31'd0, moveEnable}, {31'd0, mFlag == sn});
    end else begin
      check("R9", "moveEnable idle", {31'd0, moveEnable}, 32'd0);
    end
    mFlag = expFlag(op, a, b, ui, imm, idx, mFlag);
    lastTag = flagTag(op, ui);
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    // R1: flag cleared in and after reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "condFlag in reset", {31'd0, condFlag}, 32'd0);
    rstN = 1'b1;
    lastTag = "R1";
    doOp(4'h0, 0, 0, 0, 0, 0, 0, 0, 0, "");
    doOp(4'h1, 32'd7, 32'd7, 0, 0, 0, 0, 0, 0, "");      // R2 flag -> 1
    doOp(4'h0, 0, 0, 0, 0, 0, 0, 0, 0, "");
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R1", "condFlag cleared by reset", {31'd0, condFlag}, 32'd0);
    mFlag = 1'b0;
    rstN = 1'b1;
    lastTag = "R1";

    // R3: immediate extremes
    doOp(4'h1, 32'hFFFF_FFFC, 0, 1, 3'b100, 0, 0, 0, 0, "");  // -4 == -4
    doOp(4'h6, 32'd4, 0, 1, 3'b100, 0, 0, 0, 0, "");          // 4 == 4 unsigned
    doOp(4'h4, 32'hFFFF_FFFC, 0, 1, 3'b111, 0, 0, 0, 0, "");  // big < 7 false
    doOp(4'h2, 32'hFFFF_FFFB, 0, 1, 3'b100, 0, 0, 0, 0, "");  // -5 < -4
    doOp(4'h3, 32'd3, 0, 1, 3'b011, 0, 0, 0, 0, "");          // 3 <= 3
    doOp(4'h5, 32'd8, 0, 1, 3'b111, 0, 0, 0, 0, "");          // 8 <= 7 false
    // R2: signed vs unsigned on same registers
    doOp(4'h2, 32'h8000_0000, 32'd1, 0, 0, 0, 0, 0, 0, "");
    doOp(4'h4, 32'h8000_0000, 32'd1, 0, 0, 0, 0, 0, 0, "");
    // R4: bit test ends
    doOp(4'h7, 32'h8000_0000, 0, 0, 0, 5'd31, 0, 0, 0, "");
    doOp(4'h7, 32'h7FFF_FFFE, 0, 0, 0, 5'd0, 0, 0, 0, "");
    // R5: non-writing opcodes hold
    doOp(4'hF, 32'd1, 32'd1, 1, 3'd1, 0, 1, 0, 0, "");
    doOp(4'h9, 0, 0, 0, 0, 0, 0, 0, 0, "");
    // R7 offsets at range ends, R6 sense 0 with flag 0
    doOp(4'h8, 0, 0, 0, 0, 0, 0, 32'h0000_1000, 11'h400, "");
    doOp(4'h8, 0, 0, 0, 0, 0, 0, 32'h0000_1000, 11'h3FE, "");
    doOp(4'h8, 0, 0, 0, 0, 0, 0, 32'h0000_0002, 11'h7FC, "");
    // R8: odd offset with matching flag
    doOp(4'h8, 0, 0, 0, 0, 0, 0, 32'h100, 11'h011, "");
    // R10: compare then immediate consumer
    doOp(4'h1, 32'd5, 32'd5, 0, 0, 0, 0, 0, 0, "");
    doOp(4'h8, 0, 0, 0, 0, 0, 1, 32'h200, 11'h010, "R10");
    doOp(4'h2, 32'd9, 32'd2, 0, 0, 0, 0, 0, 0, "");
    doOp(4'h9, 0, 0, 0, 0, 0, 0, 0, 0, "R10");
    doOp(4'h7, 32'h0000_0010, 0, 0, 0, 5'd4, 0, 0, 0, "");
    doOp(4'h8, 0, 0, 0, 0, 0, 0, 32'h300, 11'h020, "R10");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [3:0]  op;
      logic [31:0] a, b;
      op = 4'($urandom_range(0, 15));
      if (op > 4'h9 && $urandom_range(0, 1) == 0) op = 4'($urandom_range(1, 9));
      a = ($urandom_range(0, 2) == 0) ? 32'($signed(4'($urandom))) : $urandom;
      b = ($urandom_range(0, 2) == 0) ? a : $urandom;
      doOp(op, a, b, 1'($urandom), 3'($urandom), 5'($urandom), 1'($urandom),
           $urandom, 11'($urandom), "");
    end
    doOp(4'h0, 0, 0, 0, 0, 0, 0, 0, 0, "");
    summary();
  end

endmodule